// File: doc/BRIEF.md
# Page Write Buffer and Write-Cycle Controller

This block sits behind a serial memory's slave engine and gathers the data bytes of one write command into a buffer that holds one page. The engine passes each data bit as it is clocked in, an acknowledge strobe for each byte, and the start, stop and word-address events. When a stop closes a command that carried only whole, acknowledged bytes, the block enters a fixed internal write time. Early in that window it sends every buffered byte to the memory array on a write strobe. The whole page costs a single write time, however many bytes it holds.

Only the low, page-local bits of the address pointer advance. A burst that runs past the end of the page wraps to the start of the same page, and later bytes replace earlier ones. A write-protect input can cancel a command once the D0 bit of the first data byte has been latched, and it can also cut short a write time that is already running. A low-supply flag blocks writes in the same way. An abort clears the buffered bytes, pulses an abort output and returns the block to idle at once.

Top module: `pw_page_writer`

## Requirements
- R1: The page offset is the low log2(PAGE_BYTES) address bits. After each acknowledged byte only those bits increment, wrapping to 0, and the upper bits stay fixed. With 8-byte pages, a burst of four bytes from 06h lands at 06h, 07h, 00h and 01h.
- R2: If more bytes arrive than a page holds, a later byte replaces the buffered byte at the same offset.
- R3: A stop that follows at least one byte of 8 bits that was also acknowledged raises busy_o in the cycle after the stop strobe.
- R4: A stop does not raise busy_o if the command has no acknowledged byte, or if some data bits or an unacknowledged full byte are pending.
- R5: busy_o stays high for exactly WRITE_CYCLES cycles. In the busy cycles 1 to PAGE_BYTES the block strobes the buffered offsets in ascending order on mem_we_o, with the full address and the byte. The whole page uses one write time.
- R6: Only offsets that received a byte in the command are strobed.
- R7: wp_i is ignored from the start strobe up to and including the cycle before the strobe of the first byte's D0 (the 8th bit). If wp_i is high on or after that strobe and before the stop, the command is cancelled, abort_o pulses for one cycle and the stop starts no write.
- R8: If wp_i is high during the write time, busy_o falls in the next cycle, abort_o pulses, and no further array strobes follow.
- R9: If low_vdd_i is high with the stop, no write starts and abort_o stays low. If low_vdd_i is high during the write time, the write aborts as in R8.
- R10: While busy_o is high, start, address, bit, acknowledge and stop strobes are ignored. They do not extend the write time or add bytes.
- R11: Starting a write, an abort and a start strobe all clear the record of buffered offsets, so the next command writes only its own bytes.
- R12: After reset busy_o, abort_o and mem_we_o are low, and data strobes are ignored until a start strobe.
- R13: Data bits arrive most significant first. The 8th bit of a byte is D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start condition strobe |
| addr_we_i | input | 1 | Load word address strobe |
| addr_i | input | ADDR_W | Word address to load |
| bit_stb_i | input | 1 | A data bit was latched |
| bit_i | input | 1 | Value of that data bit |
| ack_stb_i | input | 1 | Acknowledge of the current data byte |
| stop_i | input | 1 | Stop condition strobe |
| wp_i | input | 1 | Write protect level |
| low_vdd_i | input | 1 | Supply below the write-inhibit threshold |
| busy_o | output | 1 | Internal write time in progress |
| abort_o | output | 1 | One-cycle pulse when a write is cancelled |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
The bench builds the block with 8-byte pages, an 8-bit address and a write time of 24 cycles. With 24 cycles the whole write window, the array strobes and an abort in mid-sweep all fit in a few dozen cycles. An address of 06h shows the wrap from R1, and a ten-byte burst shows the overwrite from R2. Because the write time is short, protect and low-supply changes can be placed on an exact busy cycle, after the first strobe and before the rest.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pw_page_ptr.sv
// Word-address pointer: loadable; increments only inside its page.
module pw_page_ptr #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    inc,
  input  logic [ADDR_W-1:0]       load_val,
  output logic [ADDR_W-OFF_W-1:0] base_o,
  output logic [OFF_W-1:0]        off_o
);
  logic [ADDR_W-OFF_W-1:0] base_q;
  logic [OFF_W-1:0]        off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load) begin
      base_q <= load_val[ADDR_W-1:OFF_W];
      off_q  <= load_val[OFF_W-1:0];
    end else if (inc) begin
      off_q  <= off_q + 1'b1;   // natural wrap, no carry into base
    end
  end

  assign base_o = base_q;
  assign off_o  = off_q;
endmodule

// File: rtl/pw_page_buf.sv
// One-page byte store, written like a simple dual-port block RAM.
module pw_page_buf
  import pw_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  byte_t         wdata,
  input  logic [AW-1:0] raddr,
  output byte_t         rdata
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pw_wr_timer.sv
// Internal write-time counter; busy for exactly CYCLES cycles unless killed.
module pw_wr_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic kill,
  output logic busy_o
);
  localparam int TMR_W = $clog2(CYCLES + 1);
  logic [TMR_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (kill || cnt_q == '0) busy_q <= 1'b0;
      else                     cnt_q  <= cnt_q - 1'b1;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= TMR_W'(CYCLES - 1);
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/pw_page_writer.sv
// Page write buffer and write-cycle controller.
// WRITE_CYCLES must exceed PAGE_BYTES; PAGE_BYTES is a power of two.
module pw_page_writer
  import pw_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  input  logic              ack_stb_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              low_vdd_i,
  output logic              busy_o,
  output logic              abort_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam logic [OFF_W:0] IDX_END = (OFF_W+1)'(PAGE_BYTES);

  logic [ADDR_W-OFF_W-1:0] base;
  logic [OFF_W-1:0]        off;
  logic                    busy;
  byte_t                   rd_byte;

  logic [3:0]            bit_cnt_q;
  byte_t                 shreg_q;
  logic                  full_q, armed_q, blocked_q;
  logic [PAGE_BYTES-1:0] mask_q, cmask_q;
  logic [OFF_W:0]        idx_q;
  logic                  abort_q, we_q;
  logic [ADDR_W-1:0]     waddr_q;

  logic idle, live, d0_now, wp_abort, take_bit, take_byte, ptr_load;
  logic commit, busy_abort, sweep;

  always_comb begin
    idle       = !busy;
    live       = idle && !start_i && !stop_i && !blocked_q;
    d0_now     = bit_stb_i && !full_q && (bit_cnt_q == 4'd7);
    wp_abort   = live && wp_i && (armed_q || d0_now);
    take_bit   = live && !wp_abort && bit_stb_i && !full_q;
    take_byte  = live && !wp_abort && !bit_stb_i && ack_stb_i && full_q;
    ptr_load   = live && !wp_abort && addr_we_i;
    commit     = idle && !start_i && stop_i && (|mask_q) && (bit_cnt_q == 4'd0)
                 && !full_q && !blocked_q && !wp_i && !low_vdd_i;
    busy_abort = busy && (wp_i || low_vdd_i);
    sweep      = busy && !busy_abort && (idx_q < IDX_END);
  end

  pw_page_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .inc(take_byte),
    .load_val(addr_i), .base_o(base), .off_o(off)
  );

  pw_page_buf #(.DEPTH(PAGE_BYTES), .AW(OFF_W)) u_buf (
    .clk(clk), .we(take_byte), .waddr(off), .wdata(shreg_q),
    .raddr(idx_q[OFF_W-1:0]), .rdata(rd_byte)
  );

  pw_wr_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(commit), .kill(busy_abort), .busy_o(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      full_q    <= 1'b0;
      armed_q   <= 1'b0;
      blocked_q <= 1'b1;
      mask_q    <= '0;
      cmask_q   <= '0;
      idx_q     <= '0;
      abort_q   <= 1'b0;
      we_q      <= 1'b0;
      waddr_q   <= '0;
    end else begin
      abort_q <= wp_abort || busy_abort;
      we_q    <= sweep && cmask_q[idx_q[OFF_W-1:0]];
      if (sweep) begin
        waddr_q <= {base, idx_q[OFF_W-1:0]};
        idx_q   <= idx_q + 1'b1;
      end
      if (commit) begin
        cmask_q <= mask_q;
        idx_q   <= '0;
      end
      if (idle) begin
        if (start_i || stop_i) begin
          bit_cnt_q <= '0;
          full_q    <= 1'b0;
          armed_q   <= 1'b0;
          mask_q    <= '0;
          blocked_q <= stop_i && !start_i;
        end else if (wp_abort) begin
          mask_q    <= '0;
          armed_q   <= 1'b0;
          blocked_q <= 1'b1;
        end else if (take_bit) begin
          shreg_q   <= {shreg_q[6:0], bit_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
          if (d0_now) begin
            full_q  <= 1'b1;
            armed_q <= 1'b1;
          end
        end else if (take_byte) begin
          mask_q[off] <= 1'b1;
          full_q      <= 1'b0;
          bit_cnt_q   <= '0;
        end
      end
    end
  end

  assign busy_o     = busy;
  assign abort_o    = abort_q;
  assign mem_we_o   = we_q;
  assign mem_addr_o = waddr_q;
  assign mem_data_o = rd_byte;
endmodule

// File: rtl/pw_page_writer_chk.sv
module pw_page_writer_chk #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              stop_i,
  input logic              wp_i,
  input logic              low_vdd_i,
  input logic              busy_o,
  input logic              abort_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  p_busy_from_stop_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(stop_i));

  p_no_start_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !$past(wp_i || low_vdd_i));

  p_we_in_window_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> $past(busy_o));

  p_abort_cause_r7: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> $past(wp_i || low_vdd_i));

  p_abort_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (abort_o && $past(busy_o)) |-> !busy_o);

  p_abort_no_we_r8: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> !mem_we_o);

  p_page_fixed_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[ADDR_W-1:OFF_W] == $past(mem_addr_o[ADDR_W-1:OFF_W])));

  p_offset_ascends_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[OFF_W-1:0] == $past(mem_addr_o[OFF_W-1:0]) + 1'b1));
endmodule

bind pw_page_writer pw_page_writer_chk #(.ADDR_W(ADDR_W), .OFF_W($clog2(PAGE_BYTES))) u_chk (
  .clk(clk), .rst(rst), .stop_i(stop_i), .wp_i(wp_i), .low_vdd_i(low_vdd_i),
  .busy_o(busy_o), .abort_o(abort_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
);

// File: tb/pw_page_writer_tb.sv
module pw_page_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int P  = 8;
  localparam int W  = 24;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, addr_we_i = 0, bit_stb_i = 0, bit_i = 0, ack_stb_i = 0;
  logic stop_i = 0, wp_i = 0, low_vdd_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic busy_o, abort_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0] mem_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_page_writer #(.ADDR_W(AW), .PAGE_BYTES(P), .WRITE_CYCLES(W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_we_i(addr_we_i), .addr_i(addr_i),
    .bit_stb_i(bit_stb_i), .bit_i(bit_i), .ack_stb_i(ack_stb_i), .stop_i(stop_i),
    .wp_i(wp_i), .low_vdd_i(low_vdd_i), .busy_o(busy_o), .abort_o(abort_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
  );

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R12";
  bit done = 0;

  // ---- behavioural reference model ----
  int m_left, m_j, m_ptr, m_bits, m_sh, m_base;
  bit m_full, m_armed, m_blocked, m_abort, m_we;
  int m_addr, m_data;
  int m_buf[P];
  bit m_mask[P], m_cmask[P];

  function automatic bit any_mask();
    for (int k = 0; k < P; k++) if (m_mask[k]) return 1;
    return 0;
  endfunction

  task automatic clear_mask();
    for (int k = 0; k < P; k++) m_mask[k] = 0;
  endtask

  always @(posedge clk) begin
    m_abort = 0; m_we = 0;
    if (rst) begin
      m_left = 0; m_j = 0; m_ptr = 0; m_bits = 0; m_sh = 0; m_base = 0;
      m_full = 0; m_armed = 0; m_blocked = 1; clear_mask();
    end else if (m_left > 0) begin
      if (wp_i || low_vdd_i) begin
        m_left = 0; m_abort = 1;
      end else begin
        m_j++;
        if (m_j <= P) begin
          m_we = m_cmask[m_j-1];
          m_addr = m_base * P + m_j - 1;
          m_data = m_buf[m_j-1];
        end
        m_left--;
      end
    end else if (start_i) begin
      m_bits = 0; m_full = 0; m_armed = 0; m_blocked = 0; clear_mask();
    end else if (stop_i) begin
      if (any_mask() && m_bits == 0 && !m_full && !m_blocked && !wp_i && !low_vdd_i) begin
        m_left = W; m_j = 0; m_base = m_ptr / P;
        for (int k = 0; k < P; k++) m_cmask[k] = m_mask[k];
      end
      clear_mask(); m_bits = 0; m_full = 0; m_armed = 0; m_blocked = 1;
    end else if (!m_blocked) begin
      if (wp_i && (m_armed || (bit_stb_i && !m_full && m_bits == 7))) begin
        m_abort = 1; clear_mask(); m_blocked = 1; m_armed = 0;
      end else begin
        if (bit_stb_i && !m_full) begin
          m_sh = ((m_sh << 1) | int'(bit_i)) & 255;
          m_bits++;
          if (m_bits == 8) begin m_full = 1; m_armed = 1; end
        end else if (ack_stb_i && m_full) begin
          m_buf[m_ptr % P] = m_sh; m_mask[m_ptr % P] = 1;
          m_ptr = (m_ptr / P) * P + (m_ptr + 1) % P;
          m_full = 0; m_bits = 0;
        end
        if (addr_we_i) m_ptr = int'(addr_i);
      end
    end
  end

  // ---- per-cycle comparison and write monitor ----
  int wr_n = 0;
  logic [7:0] wr_a[32], wr_d[32];

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (busy_o !== (m_left > 0) || abort_o !== m_abort || mem_we_o !== m_we ||
          (m_we && (mem_addr_o !== m_addr[7:0] || mem_data_o !== m_data[7:0]))) begin
        failures++;
        $display("FAIL %s cycle: busy=%0b/%0b abort=%0b/%0b we=%0b/%0b addr=%h/%h data=%h/%h (act/exp)",
                 cur_req, busy_o, (m_left > 0), abort_o, m_abort, mem_we_o, m_we,
                 mem_addr_o, m_addr[7:0], mem_data_o, m_data[7:0]);
      end
      if (mem_we_o && wr_n < 32) begin
        wr_a[wr_n] = mem_addr_o; wr_d[wr_n] = mem_data_o; wr_n++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  // ---- stimulus tasks ----
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1; @(negedge clk) start_i = 0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_i = 1; @(negedge clk) stop_i = 0;
  endtask

  task automatic do_addr(input logic [7:0] a);
    @(negedge clk) begin addr_we_i = 1; addr_i = a; end
    @(negedge clk) addr_we_i = 0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input bit wp_low_at_d0);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk) begin
        bit_stb_i = 1; bit_i = b[7-i];
        if (i == 7 && wp_low_at_d0) wp_i = 0;
      end
      @(negedge clk) bit_stb_i = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8, 0);
    @(negedge clk) ack_stb_i = 1; @(negedge clk) ack_stb_i = 0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    idle(2);
  endtask

  initial begin
    idle(4);
    // R12: reset state
    check("R12", busy_o, 0, "busy in reset");
    check("R12", mem_we_o, 0, "we in reset");
    check("R12", abort_o, 0, "abort in reset");
    @(negedge clk) rst = 0;
    // R12: data ignored before any start
    cur_req = "R12"; wr_n = 0;
    do_addr(8'h00); send_byte(8'h77); do_stop(); idle(2);
    check("R12", busy_o, 0, "busy after bytes without start");

    // R1 / R13 / R3 / R5: wrap within page from 06h, MSB-first bits
    cur_req = "R1"; wr_n = 0;
    do_start(); do_addr(8'h06);
    send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3); send_byte(8'hD4);
    do_stop();
    check("R3", busy_o, 1, "busy one cycle after stop");
    begin
      int width = 0;
      while (busy_o) begin width++; @(negedge clk); end
      check("R5", width, W, "busy width");
    end
    idle(2);
    check("R1", wr_n, 4, "write count");
    check("R1", wr_a[0], 8'h00, "first addr"); check("R1", wr_d[0], 8'hC3, "data at 00h");
    check("R1", wr_a[1], 8'h01, "second addr"); check("R13", wr_d[1], 8'hD4, "data at 01h");
    check("R1", wr_a[2], 8'h06, "third addr"); check("R13", wr_d[2], 8'hA1, "data at 06h");
    check("R1", wr_a[3], 8'h07, "fourth addr"); check("R1", wr_d[3], 8'hB2, "data at 07h");

    // R2: ten bytes into an 8-byte page
    cur_req = "R2"; wr_n = 0;
    do_start(); do_addr(8'h10);
    for (int i = 0; i < 10; i++) send_byte(8'(i));
    do_stop(); wait_idle();
    check("R2", wr_n, 8, "write count");
    check("R2", wr_d[0], 8, "offset0 overwritten");
    check("R2", wr_d[1], 9, "offset1 overwritten");
    check("R2", wr_d[7], 7, "offset7 kept");

    // R6: partial page
    cur_req = "R6"; wr_n = 0;
    do_start(); do_addr(8'h63);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    do_stop(); wait_idle();
    check("R6", wr_n, 3, "only written offsets");
    check("R6", wr_a[0], 8'h63, "first strobed addr");

    // R4: no bytes / partial bits / unacknowledged byte
    cur_req = "R4";
    do_start(); do_addr(8'h20); do_stop(); idle(1);
    check("R4", busy_o, 0, "stop with no data");
    do_start(); do_addr(8'h20); send_byte(8'h5A); send_bits(8'hFF, 3, 0); do_stop(); idle(1);
    check("R4", busy_o, 0, "stop mid byte");
    do_start(); do_addr(8'h20); send_bits(8'h3C, 8, 0); do_stop(); idle(1);
    check("R4", busy_o, 0, "stop before ack");

    // R7: wp high before first D0 is ignored
    cur_req = "R7"; wr_n = 0;
    @(negedge clk) wp_i = 1;
    do_start(); do_addr(8'h48);
    send_bits(8'h9C, 8, 1);
    @(negedge clk) ack_stb_i = 1; @(negedge clk) ack_stb_i = 0;
    do_stop(); wait_idle();
    check("R7", wr_n, 1, "write despite early wp");
    check("R7", wr_d[0], 8'h9C, "early wp data");

    // R7: wp high after first D0 cancels
    wr_n = 0;
    do_start(); do_addr(8'h30);
    send_byte(8'hE1); send_byte(8'hE2);
    @(negedge clk) wp_i = 1;
    @(negedge clk) check("R7", abort_o, 1, "abort pulse");
    @(negedge clk) wp_i = 0;
    send_byte(8'hE3);
    do_stop(); idle(1);
    check("R7", busy_o, 0, "no write after cancel");

    // R11: next command writes only its own byte
    cur_req = "R11"; wr_n = 0;
    do_start(); do_addr(8'h31); send_byte(8'h4B); do_stop(); wait_idle();
    check("R11", wr_n, 1, "single write after abort");
    check("R11", wr_a[0], 8'h31, "single write addr");

    // R8: wp during write time
    cur_req = "R8"; wr_n = 0;
    do_start(); do_addr(8'h50);
    for (int i = 0; i < 4; i++) send_byte(8'h80 + 8'(i));
    do_stop();
    @(negedge clk) wp_i = 1;
    @(negedge clk) begin
      check("R8", abort_o, 1, "abort in write time");
      check("R8", busy_o, 0, "busy dropped");
    end
    @(negedge clk) wp_i = 0;
    idle(10);
    check("R8", wr_n, 1, "strobes stop at abort");

    // R9: low supply at stop, then during write time
    cur_req = "R9"; wr_n = 0;
    do_start(); do_addr(8'h70); send_byte(8'h12);
    @(negedge clk) begin low_vdd_i = 1; stop_i = 1; end
    @(negedge clk) begin stop_i = 0; low_vdd_i = 0; end
    check("R9", busy_o, 0, "no write at low supply");
    check("R9", abort_o, 0, "no abort at low supply stop");
    do_start(); do_addr(8'h70); send_byte(8'h12); do_stop();
    idle(12);
    @(negedge clk) low_vdd_i = 1;
    @(negedge clk) check("R9", busy_o, 0, "low supply aborts write");
    low_vdd_i = 0; idle(2);

    // R10: commands during write time are ignored
    cur_req = "R10"; wr_n = 0;
    do_start(); do_addr(8'h20); send_byte(8'h01); send_byte(8'h02); do_stop();
    begin
      int width = 1;
      fork
        begin do_start(); do_addr(8'h40); send_byte(8'h55); do_stop(); end
        begin while (busy_o) begin @(negedge clk); if (busy_o) width++; end end
      join
      check("R10", width, W, "busy not extended");
    end
    wait_idle();
    check("R10", wr_n, 2, "bytes during busy dropped");

    idle(4);
    finish_run();
  end
endmodule